// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, for every received Ethernet frame, whether the frame is kept. It collects the six destination octets as they arrive at the head of the frame. It also takes a CRC-32 of those six octets, computed elsewhere. It then compares the address against a set of programmed exact-match slots and a multicast hash table. The promiscuous and hash-enable control bits are applied to the result.

One clock after the last destination octet is captured, it raises a decision-valid flag. With that flag come an accept bit and a 6-bit match-class field for the receive descriptor. Both hold until the next frame is announced.

Slot 0 carries the station's own unicast address. The remaining slots carry multicast group addresses. The hash table covers groups beyond the slot count. Software programs every slot, hash word and control bit through a 16-bit write-only port.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, `dec_valid`, `rx_accept` and `match_status` are 0, and every slot, hash word and control bit is cleared.
- R2: Octets are taken on `oct_valid`, the first one into bits 7:0 of the 48-bit address. A `frm_start` cycle restarts the count, and its octet, if any, counts as the first. `dec_valid` rises on the clock edge that follows the edge capturing the sixth octet. Further octets before the next `frm_start` are ignored.
- R3: Once `dec_valid` is high, `rx_accept` and `match_status` stay unchanged until `frm_start`. The edge after `frm_start` clears all three outputs.
- R4: A non-broadcast destination equal to the nonzero slot 0 is accepted with `match_status[2]` set and index bits 1:0 equal to 0.
- R5: A multicast destination equal to a nonzero slot 1..3 is accepted with bit 2 set and bits 1:0 giving the slot; the lowest matching slot wins. An all-zero slot never matches. With no exact hit, bits 1:0 are 0.
- R6: A destination of all ones is broadcast. It sets `match_status[5]`, is always accepted, and does not set the multicast bit.
- R7: A non-broadcast destination with bit 0 of its first octet set is multicast and sets `match_status[4]`.
- R8: With control bit 8 set, a multicast frame looks up hash bit `crc[31:26]`. Index bits 5:4 pick the hash word and bits 3:0 pick the bit within it. A set bit accepts the frame and sets `match_status[3]`. With control bit 8 clear, or for a non-multicast frame, no hash hit is reported. All hash words at 0xFFFF accept every multicast frame.
- R9: With control bit 5 set, every frame is accepted, and `match_status` keeps the class bits it would otherwise have.
- R10: Write map:
  - control word at address 0; only bits 5 and 8 are kept.
  - hash word k at address 4+k.
  - slot s word w at address 8+4s+w, with w=0 the low word holding octets 0 (bits 7:0) and 1.
  A write on the edge that captures the sixth octet is used by that frame's decision. A write on the decision edge is not.
- R11: A frame that is not broadcast, hits no slot and no hash bit, and arrives outside promiscuous mode is rejected with `match_status` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| frm_start | input | 1 | New frame begins; clears the previous decision |
| oct_valid | input | 1 | Destination octet present on `oct_data` |
| oct_data | input | 8 | Destination octet, first octet first |
| dst_crc | input | 32 | CRC-32 of the destination, valid with the sixth octet |
| dec_valid | output | 1 | Decision available |
| rx_accept | output | 1 | Frame accepted |
| match_status | output | 6 | {broadcast, multicast, hash hit, slot hit, slot index[1:0]} |

## Verification
The two functions that can meet in one cycle are a configuration write and the completion of a frame's address. The bench puts a write to slot 0 either on the edge that captures the sixth octet or on the following decision edge. In both cases it sends the station's own unicast address. A write on the capture edge must already steer the decision, so the frame is rejected. A write on the decision edge must not, so the frame is accepted, and the next frame shows that the write did land.

// File: rtl/daf_pkg.sv
package daf_pkg;
   localparam int WORD_W      = 16;
   localparam int OCT_W       = 8;
   localparam int IDX_W       = 2;
   localparam int STAT_W      = 6;
   localparam int PROMISC_BIT = 5;
   localparam int HASH_EN_BIT = 8;

   typedef struct packed {
      logic             bcast;
      logic             mcast;
      logic             hash_hit;
      logic             exact_hit;
      logic [IDX_W-1:0] idx;
   } match_stat_t;
endpackage

// File: rtl/daf_cfg_regs.sv
module daf_cfg_regs
   import daf_pkg::*;
#(
   parameter int NUM_SLOTS   = 4,
   parameter int HASH_WORDS  = 4,
   parameter int WPS         = 3,
   parameter int AW          = 5,
   parameter int HASH_BASE   = 4,
   parameter int SLOT_BASE   = 8,
   parameter int SLOT_STRIDE = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_we,
   input  logic [AW-1:0]                   cfg_addr,
   input  logic [WORD_W-1:0]               cfg_wdata,
   output logic                            promisc_o,
   output logic                            hash_en_o,
   output logic [HASH_WORDS*WORD_W-1:0]    hash_o,
   output logic [NUM_SLOTS*WPS*WORD_W-1:0] slot_o
);
   localparam logic [AW-1:0] CTRL_ADDR = '0;

   logic promisc_q, hash_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         promisc_q <= 1'b0;
         hash_en_q <= 1'b0;
      end else if (cfg_we && cfg_addr == CTRL_ADDR) begin
         promisc_q <= cfg_wdata[PROMISC_BIT];
         hash_en_q <= cfg_wdata[HASH_EN_BIT];
      end
   end

   for (genvar k = 0; k < HASH_WORDS; k++) begin : g_hash
      localparam logic [AW-1:0] MY_ADDR = AW'(HASH_BASE + k);
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            word_q <= '0;
         else if (cfg_we && cfg_addr == MY_ADDR) word_q <= cfg_wdata;
      end
      assign hash_o[k*WORD_W +: WORD_W] = word_q;
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      for (genvar w = 0; w < WPS; w++) begin : g_word
         localparam logic [AW-1:0] MY_ADDR = AW'(SLOT_BASE + SLOT_STRIDE*s + w);
         logic [WORD_W-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            word_q <= '0;
            else if (cfg_we && cfg_addr == MY_ADDR) word_q <= cfg_wdata;
         end
         assign slot_o[(s*WPS + w)*WORD_W +: WORD_W] = word_q;
      end
   end

   assign promisc_o = promisc_q;
   assign hash_en_o = hash_en_q;

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ($stable(hash_o) && $stable(slot_o) && $stable(promisc_o) && $stable(hash_en_o))); // R10
endmodule

// File: rtl/daf_capture.sv
module daf_capture
   import daf_pkg::*;
#(
   parameter int OCTETS = 6,
   parameter int CRC_W  = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frm_start,
   input  logic                  oct_valid,
   input  logic [OCT_W-1:0]      oct_data,
   input  logic [CRC_W-1:0]      crc_in,
   output logic [OCTETS*OCT_W-1:0] dst_o,
   output logic [CRC_W-1:0]      crc_o,
   output logic                  done_o
);
   localparam int CW = $clog2(OCTETS + 1);
   localparam logic [CW-1:0] LAST = CW'(OCTETS - 1);
   localparam logic [CW-1:0] FULL = CW'(OCTETS);

   logic [CW-1:0]          cnt_q, idx;
   logic [OCTETS*OCT_W-1:0] dst_q;
   logic [CRC_W-1:0]       crc_q;
   logic                   done_q, take;

   always_comb begin
      idx  = frm_start ? '0 : cnt_q;
      take = oct_valid && (idx < FULL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         dst_q  <= '0;
         crc_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         cnt_q  <= take ? idx + 1'b1 : idx;
         if (take) begin
            dst_q[idx*OCT_W +: OCT_W] <= oct_data;
            if (idx == LAST) begin
               crc_q  <= crc_in;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign dst_o  = dst_q;
   assign crc_o  = crc_q;
   assign done_o = done_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == FULL && !frm_start) |=> (cnt_q == FULL && !done_o)); // R2
endmodule

// File: rtl/daf_match.sv
module daf_match
   import daf_pkg::*;
#(
   parameter int NUM_SLOTS  = 4,
   parameter int HASH_WORDS = 4,
   parameter int ADDR_W     = 48,
   parameter int CRC_W      = 32
) (
   input  logic [ADDR_W-1:0]            dst,
   input  logic [CRC_W-1:0]             crc,
   input  logic                         promisc,
   input  logic                         hash_en,
   input  logic [HASH_WORDS*WORD_W-1:0] hash_tbl,
   input  logic [NUM_SLOTS*ADDR_W-1:0]  slots,
   output logic                         accept_o,
   output match_stat_t                  stat_o
);
   localparam int HIDX_W = $clog2(HASH_WORDS * WORD_W);

   logic                 is_bcast, is_mcast;
   logic [NUM_SLOTS-1:0] slot_hit;
   logic [IDX_W-1:0]     hit_idx;
   logic                 hash_bit;
   logic [HIDX_W-1:0]    hidx;

   assign is_bcast = &dst;
   assign is_mcast = dst[0] & ~is_bcast;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
      logic [ADDR_W-1:0] slot_val;
      logic              class_ok;
      assign slot_val = slots[s*ADDR_W +: ADDR_W];
      if (s == 0) begin : g_station
         assign class_ok = ~is_bcast;
      end else begin : g_group
         assign class_ok = is_mcast;
      end
      assign slot_hit[s] = (|slot_val) & class_ok & (dst == slot_val);
   end

   always_comb begin
      hit_idx = '0;
      for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
         if (slot_hit[s]) hit_idx = IDX_W'(s);
      end
   end

   assign hidx     = crc[CRC_W-1 -: HIDX_W];
   assign hash_bit = hash_tbl[hidx];

   always_comb begin
      stat_o.bcast     = is_bcast;
      stat_o.mcast     = is_mcast;
      stat_o.hash_hit  = hash_en & is_mcast & hash_bit;
      stat_o.exact_hit = |slot_hit;
      stat_o.idx       = hit_idx;
      accept_o = promisc | is_bcast | stat_o.exact_hit | stat_o.hash_hit;
   end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
   import daf_pkg::*;
#(
   parameter int NUM_SLOTS   = 4,
   parameter int HASH_WORDS  = 4,
   parameter int ADDR_OCTETS = 6,
   parameter int CRC_W       = 32,
   parameter int CFG_AW      = 5,
   parameter int HASH_BASE   = 4,
   parameter int SLOT_BASE   = 8,
   parameter int SLOT_STRIDE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [15:0]       cfg_wdata,
   input  logic              frm_start,
   input  logic              oct_valid,
   input  logic [7:0]        oct_data,
   input  logic [CRC_W-1:0]  dst_crc,
   output logic              dec_valid,
   output logic              rx_accept,
   output logic [5:0]        match_status
);
   localparam int ADDR_W = ADDR_OCTETS * OCT_W;
   localparam int WPS    = ADDR_W / WORD_W;
   localparam int HIDX_W = $clog2(HASH_WORDS * WORD_W);

   if (NUM_SLOTS < 1 || NUM_SLOTS > (1 << IDX_W)) begin : g_bad_slots
      $error("slot count must fit the 2-bit index field");
   end
   if ((HASH_WORDS * WORD_W) != (1 << HIDX_W) || HIDX_W > CRC_W) begin : g_bad_hash
      $error("hash size must be a power of two no wider than the CRC");
   end
   if ((ADDR_W % WORD_W) != 0 || WPS > SLOT_STRIDE) begin : g_bad_addr
      $error("address must be whole words and fit the slot stride");
   end
   if (SLOT_BASE + SLOT_STRIDE*NUM_SLOTS > (1 << CFG_AW) || HASH_BASE + HASH_WORDS > SLOT_BASE
       || HASH_BASE < 1) begin : g_bad_map
      $error("register map does not fit the address width");
   end

   logic                         promisc, hash_en, cap_done, acc_c;
   logic [HASH_WORDS*WORD_W-1:0] hash_tbl;
   logic [NUM_SLOTS*ADDR_W-1:0]  slots;
   logic [ADDR_W-1:0]            dst;
   logic [CRC_W-1:0]             crc;
   match_stat_t                  stat_c, stat_q;
   logic                         valid_q, acc_q;

   daf_cfg_regs #(
      .NUM_SLOTS(NUM_SLOTS), .HASH_WORDS(HASH_WORDS), .WPS(WPS), .AW(CFG_AW),
      .HASH_BASE(HASH_BASE), .SLOT_BASE(SLOT_BASE), .SLOT_STRIDE(SLOT_STRIDE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .promisc_o(promisc), .hash_en_o(hash_en), .hash_o(hash_tbl), .slot_o(slots)
   );

   daf_capture #(.OCTETS(ADDR_OCTETS), .CRC_W(CRC_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .oct_valid(oct_valid),
      .oct_data(oct_data), .crc_in(dst_crc), .dst_o(dst), .crc_o(crc), .done_o(cap_done)
   );

   daf_match #(
      .NUM_SLOTS(NUM_SLOTS), .HASH_WORDS(HASH_WORDS), .ADDR_W(ADDR_W), .CRC_W(CRC_W)
   ) u_match (
      .dst(dst), .crc(crc), .promisc(promisc), .hash_en(hash_en), .hash_tbl(hash_tbl),
      .slots(slots), .accept_o(acc_c), .stat_o(stat_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         acc_q   <= 1'b0;
         stat_q  <= '0;
      end else if (frm_start) begin
         valid_q <= 1'b0;
         acc_q   <= 1'b0;
         stat_q  <= '0;
      end else if (cap_done) begin
         valid_q <= 1'b1;
         acc_q   <= acc_c;
         stat_q  <= stat_c;
      end
   end

   assign dec_valid    = valid_q;
   assign rx_accept    = acc_q;
   assign match_status = stat_q;

   AST_VALID_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dec_valid) |-> $past(cap_done)); // R2
   AST_DECISION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !frm_start) |=> (dec_valid && $stable(rx_accept) && $stable(match_status))); // R3
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      frm_start |=> (!dec_valid && !rx_accept && match_status == '0)); // R3
   AST_BCAST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && match_status[5]) |-> (rx_accept && !match_status[4])); // R6
   AST_IDX_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !match_status[2]) |-> (match_status[1:0] == 2'b00)); // R5
   AST_HASH_ON_MCAST: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && match_status[3]) |-> (match_status[4] && rx_accept)); // R8
endmodule

// File: tb/dst_addr_filter_tb_top.sv
`timescale 1ns/1ps
module dst_addr_filter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        frm_start = 1'b0;
   logic        oct_valid = 1'b0;
   logic [7:0]  oct_data = '0;
   logic [31:0] dst_crc = '0;
   logic        dec_valid, rx_accept;
   logic [5:0]  match_status;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dst_addr_filter dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .frm_start(frm_start), .oct_valid(oct_valid), .oct_data(oct_data), .dst_crc(dst_crc),
      .dec_valid(dec_valid), .rx_accept(rx_accept), .match_status(match_status)
   );

   typedef struct packed {
      logic [47:0] dst;
      logic [31:0] crc;
      logic [1:0]  ctl;   // {promiscuous, hash enable}
      logic        acc;
      logic [5:0]  st;
   } vec_t;

   localparam logic [47:0] OWN   = 48'h5544_3322_1102;
   localparam logic [47:0] OTHER = 48'h5544_3322_1104;
   localparam logic [47:0] GRP1  = 48'h0100_005e_0001;
   localparam logic [47:0] GRP3  = 48'hfb00_0000_3333;
   localparam logic [47:0] GRPX  = 48'h0200_005e_0001;

   localparam vec_t VECS [11] = '{
      '{OWN,        32'h0,         2'b00, 1'b1, 6'h04},  // R4
      '{OTHER,      32'h0,         2'b00, 1'b0, 6'h00},  // R11
      '{OTHER,      32'h0,         2'b10, 1'b1, 6'h00},  // R9
      '{48'hffff_ffff_ffff, 32'h0, 2'b00, 1'b1, 6'h20},  // R6
      '{GRP1,       32'h0,         2'b00, 1'b1, 6'h15},  // R5 slot 1
      '{GRP3,       32'h0,         2'b00, 1'b1, 6'h17},  // R5 slot 3
      '{GRPX,       32'h9000_0000, 2'b01, 1'b1, 6'h18},  // R8 hit word2 bit4
      '{GRPX,       32'h9000_0000, 2'b00, 1'b0, 6'h10},  // R8 disabled, R7
      '{GRPX,       32'h0000_0000, 2'b01, 1'b0, 6'h10},  // R8 miss
      '{GRP1,       32'h9000_0000, 2'b01, 1'b1, 6'h1d},  // R8 + R5 together
      '{48'h0,      32'h0,         2'b00, 1'b0, 6'h00}   // R5 zero slot unused
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wr_slot(input int s, input logic [47:0] v);
      for (int w = 0; w < 3; w++) wr(5'(8 + 4*s + w), v[16*w +: 16]);
   endtask

   // mode: 0 none, 1 write with last octet, 2 write on decision edge
   task automatic frame(input logic [47:0] d, input logic [31:0] c,
                        input int mode, input logic [4:0] wa, input logic [15:0] wd);
      @(negedge clk);
      frm_start = 1'b1;
      @(negedge clk);
      frm_start = 1'b0;
      for (int i = 0; i < 6; i++) begin
         oct_valid = 1'b1; oct_data = d[8*i +: 8]; dst_crc = c;
         if (i == 5 && mode == 1) begin cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd; end
         @(negedge clk);
         cfg_we = 1'b0;
      end
      oct_valid = 1'b0; dst_crc = '0;
      if (mode == 2) begin cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd; end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset outputs", {13'b0, dec_valid, rx_accept, 1'b0}, 16'h0);
      chk("R1 reset status", {10'b0, match_status}, 16'h0);
      frame(OTHER, 32'h0, 0, 5'd0, 16'h0);
      chk("R1 cleared regs reject", {14'b0, dec_valid, rx_accept}, 16'h2);

      wr_slot(0, OWN); wr_slot(1, GRP1); wr_slot(3, GRP3);
      wr(5'd6, 16'h0010);

      foreach (VECS[k]) begin
         wr(5'd0, {7'b0, VECS[k].ctl[0], 2'b0, VECS[k].ctl[1], 5'b0});
         frame(VECS[k].dst, VECS[k].crc, 0, 5'd0, 16'h0);
         chk($sformatf("R2 valid vec%0d", k), {15'b0, dec_valid}, 16'h1);
         chk($sformatf("R4-R11 accept vec%0d", k), {15'b0, rx_accept}, {15'b0, VECS[k].acc});
         chk($sformatf("R4-R11 status vec%0d", k), {10'b0, match_status}, {10'b0, VECS[k].st});
      end

      // R2 extra octets ignored, R3 held
      wr(5'd0, 16'h0);
      frame(OWN, 32'h0, 0, 5'd0, 16'h0);
      for (int i = 0; i < 3; i++) begin
         oct_valid = 1'b1; oct_data = 8'hff;
         @(negedge clk);
      end
      oct_valid = 1'b0;
      @(negedge clk);
      chk("R2 R3 held after extra octets", {8'b0, dec_valid, rx_accept, match_status}, 16'h0c4);
      frm_start = 1'b1;
      @(negedge clk);
      frm_start = 1'b0;
      chk("R3 start clears", {8'b0, dec_valid, rx_accept, match_status}, 16'h0);

      // R10 unused control bits ignored
      wr(5'd0, 16'hfedf);
      frame(OTHER, 32'h0, 0, 5'd0, 16'h0);
      chk("R10 unused ctrl bits", {15'b0, rx_accept}, 16'h0);

      // R8 all-ones hash table
      for (int k = 0; k < 4; k++) wr(5'(4 + k), 16'hffff);
      wr(5'd0, 16'h0100);
      frame(GRPX, 32'h1234_5678, 0, 5'd0, 16'h0);
      chk("R8 all-ones hash", {9'b0, rx_accept, match_status}, 16'h058);

      // R10 write collisions
      wr(5'd0, 16'h0);
      frame(OWN, 32'h0, 1, 5'd8, 16'hbeef);
      chk("R10 write with last octet used", {9'b0, rx_accept, match_status}, 16'h000);
      wr(5'd8, 16'h1102);
      frame(OWN, 32'h0, 2, 5'd8, 16'hbeef);
      chk("R10 write on decision edge unused", {9'b0, rx_accept, match_status}, 16'h044);
      frame(OWN, 32'h0, 0, 5'd0, 16'h0);
      chk("R10 decision-edge write landed", {15'b0, rx_accept}, 16'h0);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule